// File: doc/BRIEF.md
# TLB Fault Address Capture

When the address translation unit flags a fault on an access, this block works out the new contents of the translation-related coprocessor registers: the bad-address register, the entry-high register, and either the 32-bit or the 64-bit context register. It also works out the exception vector offset and the exception code that the exception entry unit needs. The faulting virtual address, the fault kind, the access direction, the addressing mode, the exception-level status bit and the present values of the entry-high and both context registers are sampled on a one-cycle capture strobe. The results appear on registered outputs. The coprocessor writes these outputs back into its register file.

In 64-bit mode the entry-high result carries the address region and a 27-bit page-pair number. The 64-bit context register gets the same two fields, packed lower down. In 32-bit mode a 19-bit page-pair number is used, and the entry-high result is sign-extended from bit 31. In both modes the address-space identifier already held in entry-high is kept. A context register that the active mode does not touch is passed through unchanged.

Top module: `tlbf_capture`

## Requirements
- R1: While `rst` is high, and after it until the first capture, every output is zero.
- R2: In a cycle where `cap_i` is low, no output changes, whatever the other inputs do.
- R3: On a capture, `badvaddr_o` becomes the full 64-bit `vaddr_i`.
- R4: On a capture with `wide_i`=1, `entryhi_o` has `vaddr_i[63:62]` in bits 63:62, `vaddr_i[39:13]` in bits 39:13, `cur_entryhi_i[7:0]` in bits 7:0, and zero in every other bit.
- R5: On a capture with `wide_i`=1, `xcontext_o` equals `cur_xcontext_i` except that bits 32:31 hold `vaddr_i[63:62]` and bits 30:4 hold `vaddr_i[39:13]`. `context_o` equals `cur_context_i`.
- R6: On a capture with `wide_i`=0, bits 31:0 of `entryhi_o` hold `{vaddr_i[31:13], 5'b0, cur_entryhi_i[7:0]}`, and bits 63:32 are copies of bit 31.
- R7: On a capture with `wide_i`=0, `context_o` equals `cur_context_i` except that bits 22:4 hold `vaddr_i[31:13]`. `xcontext_o` equals `cur_xcontext_i`.
- R8: A capture with `kind_i`=0 (miss) and `exl_i`=0 sets `vec_off_o` to 0x080 when `wide_i`=1 and to 0x000 when `wide_i`=0.
- R9: A capture with `kind_i`=0 (miss) and `exl_i`=1 sets `vec_off_o` to 0x180 in both modes.
- R10: A capture with `kind_i`=1 (invalid entry), `kind_i`=2 (modify) or `kind_i`=3 (handled as invalid entry) sets `vec_off_o` to 0x180, regardless of mode and `exl_i`.
- R11: `exc_code_o` becomes 1 for `kind_i`=2. For every other kind it becomes 3 when `store_i`=1 and 2 when `store_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_i | input | 1 | Capture strobe, one cycle per fault |
| kind_i | input | 2 | Fault kind: 0 miss, 1 invalid entry, 2 modify, 3 handled as invalid |
| store_i | input | 1 | Faulting access was a store |
| vaddr_i | input | 64 | Faulting virtual address |
| wide_i | input | 1 | 1 selects 64-bit addressing layout |
| exl_i | input | 1 | Exception-level status bit (status bit 1) |
| cur_entryhi_i | input | 64 | Present entry-high value (ASID source) |
| cur_context_i | input | 64 | Present 32-bit-mode context register |
| cur_xcontext_i | input | 64 | Present 64-bit-mode context register |
| badvaddr_o | output | 64 | New bad-address value |
| entryhi_o | output | 64 | New entry-high value |
| context_o | output | 64 | New 32-bit-mode context value |
| xcontext_o | output | 64 | New 64-bit-mode context value |
| vec_off_o | output | 9 | Exception vector offset |
| exc_code_o | output | 5 | Exception code |

## Verification
The hardest case to hit is a capture where preserved bits and replaced bits meet. It needs a context register whose untouched bits are all ones, a narrow-mode address with bit 31 set so that entry-high is sign-extended, and a miss taken with the exception-level bit set. Random stimulus seldom lines all of these up. Directed captures therefore use all-ones and all-zeros register values with each combination of mode and exception-level bit. Random captures are mixed with idle cycles in which every other input still changes, to show that the outputs hold.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    typedef enum logic [1:0] {
        FK_MISS    = 2'd0,
        FK_INVALID = 2'd1,
        FK_MODIFY  = 2'd2,
        FK_SPARE   = 2'd3
    } fault_kind_e;

    localparam int VEC_W = 9;
    localparam int EXC_W = 5;

    localparam logic [VEC_W-1:0] OFF_REFILL_NARROW = 9'h000;
    localparam logic [VEC_W-1:0] OFF_REFILL_WIDE   = 9'h080;
    localparam logic [VEC_W-1:0] OFF_GENERAL       = 9'h180;

    localparam logic [EXC_W-1:0] EXC_MOD   = 5'd1;
    localparam logic [EXC_W-1:0] EXC_LOAD  = 5'd2;
    localparam logic [EXC_W-1:0] EXC_STORE = 5'd3;

    typedef struct packed {
        logic [VEC_W-1:0] off;
        logic [EXC_W-1:0] code;
    } vec_sel_t;

    function automatic vec_sel_t pick_vector(fault_kind_e kind, logic store,
                                             logic wide, logic exl);
        vec_sel_t r;
        if (kind == FK_MISS && !exl)
            r.off = wide ? OFF_REFILL_WIDE : OFF_REFILL_NARROW;
        else
            r.off = OFF_GENERAL;
        if (kind == FK_MODIFY)
            r.code = EXC_MOD;
        else
            r.code = store ? EXC_STORE : EXC_LOAD;
        return r;
    endfunction

endpackage

// File: rtl/tlbf_vector.sv
module tlbf_vector
    import tlbf_pkg::*;
(
    input  fault_kind_e kind_i,
    input  logic        store_i,
    input  logic        wide_i,
    input  logic        exl_i,
    output vec_sel_t    sel_o
);
    always_comb begin
        sel_o = pick_vector(kind_i, store_i, wide_i, exl_i);
    end
endmodule

// File: rtl/tlbf_layout.sv
module tlbf_layout #(
    parameter bit WIDE       = 1'b1,
    parameter int REG_W      = 64,
    parameter int ASID_W     = 8,
    parameter int PAGE_SHIFT = 13,
    parameter int CTX_SHIFT  = 4,
    parameter int VPN2_W     = 27,
    parameter int REGION_W   = 2
) (
    input  logic [REG_W-1:0] vaddr_i,
    input  logic [REG_W-1:0] cur_entryhi_i,
    input  logic [REG_W-1:0] cur_ctx_i,
    output logic [REG_W-1:0] entryhi_o,
    output logic [REG_W-1:0] ctx_o
);
    localparam int NARROW_W = PAGE_SHIFT + VPN2_W;
    localparam int REGION_POS = CTX_SHIFT + VPN2_W;

    logic [VPN2_W-1:0]   vpn2;
    logic [REGION_W-1:0] region;
    logic [ASID_W-1:0]   asid;
    logic                unused_in;

    assign vpn2      = vaddr_i[PAGE_SHIFT +: VPN2_W];
    assign region    = vaddr_i[REG_W-1 -: REGION_W];
    assign asid      = cur_entryhi_i[ASID_W-1:0];
    assign unused_in = ^{vaddr_i, cur_entryhi_i};

    generate
        if (WIDE) begin : g_wide
            always_comb begin
                entryhi_o = '0;
                entryhi_o[REG_W-1 -: REGION_W]  = region;
                entryhi_o[PAGE_SHIFT +: VPN2_W] = vpn2;
                entryhi_o[ASID_W-1:0]           = asid;
                ctx_o = cur_ctx_i;
                ctx_o[CTX_SHIFT +: VPN2_W]      = vpn2;
                ctx_o[REGION_POS +: REGION_W]   = region;
            end
        end else begin : g_narrow
            logic [NARROW_W-1:0] lo;
            always_comb begin
                lo = '0;
                lo[PAGE_SHIFT +: VPN2_W] = vpn2;
                lo[ASID_W-1:0]           = asid;
                entryhi_o = {{(REG_W-NARROW_W){lo[NARROW_W-1]}}, lo};
                ctx_o = cur_ctx_i;
                ctx_o[CTX_SHIFT +: VPN2_W] = vpn2;
            end
        end
    endgenerate
endmodule

// File: rtl/tlbf_capture.sv
module tlbf_capture
    import tlbf_pkg::*;
#(
    parameter int REG_W      = 64,
    parameter int ASID_W     = 8,
    parameter int PAGE_SHIFT = 13,
    parameter int CTX_SHIFT  = 4,
    parameter int VPN2_W64   = 27,
    parameter int VPN2_W32   = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_i,
    input  logic [1:0]       kind_i,
    input  logic             store_i,
    input  logic [REG_W-1:0] vaddr_i,
    input  logic             wide_i,
    input  logic             exl_i,
    input  logic [REG_W-1:0] cur_entryhi_i,
    input  logic [REG_W-1:0] cur_context_i,
    input  logic [REG_W-1:0] cur_xcontext_i,
    output logic [REG_W-1:0] badvaddr_o,
    output logic [REG_W-1:0] entryhi_o,
    output logic [REG_W-1:0] context_o,
    output logic [REG_W-1:0] xcontext_o,
    output logic [VEC_W-1:0] vec_off_o,
    output logic [EXC_W-1:0] exc_code_o
);
    localparam int MODES = 2;

    typedef struct packed {
        logic [REG_W-1:0] badv;
        logic [REG_W-1:0] ehi;
        logic [REG_W-1:0] ctx;
        logic [REG_W-1:0] xctx;
        vec_sel_t         vec;
    } capture_t;

    logic [REG_W-1:0] ehi_by_mode [MODES];
    logic [REG_W-1:0] ctx_by_mode [MODES];
    vec_sel_t         vec_next;
    capture_t         nxt, q;

    generate
        for (genvar m = 0; m < MODES; m++) begin : g_mode
            tlbf_layout #(
                .WIDE       (m == 1),
                .REG_W      (REG_W),
                .ASID_W     (ASID_W),
                .PAGE_SHIFT (PAGE_SHIFT),
                .CTX_SHIFT  (CTX_SHIFT),
                .VPN2_W     ((m == 1) ? VPN2_W64 : VPN2_W32)
            ) u_layout (
                .vaddr_i       (vaddr_i),
                .cur_entryhi_i (cur_entryhi_i),
                .cur_ctx_i     ((m == 1) ? cur_xcontext_i : cur_context_i),
                .entryhi_o     (ehi_by_mode[m]),
                .ctx_o         (ctx_by_mode[m])
            );
        end
    endgenerate

    tlbf_vector u_vector (
        .kind_i  (fault_kind_e'(kind_i)),
        .store_i (store_i),
        .wide_i  (wide_i),
        .exl_i   (exl_i),
        .sel_o   (vec_next)
    );

    always_comb begin
        nxt.badv = vaddr_i;
        nxt.ehi  = wide_i ? ehi_by_mode[1] : ehi_by_mode[0];
        nxt.ctx  = wide_i ? cur_context_i  : ctx_by_mode[0];
        nxt.xctx = wide_i ? ctx_by_mode[1] : cur_xcontext_i;
        nxt.vec  = vec_next;
    end

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (cap_i) q <= nxt;
    end

    assign badvaddr_o = q.badv;
    assign entryhi_o  = q.ehi;
    assign context_o  = q.ctx;
    assign xcontext_o = q.xctx;
    assign vec_off_o  = q.vec.off;
    assign exc_code_o = q.vec.code;
endmodule

// File: rtl/tlbf_capture_chk.sv
module tlbf_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic        cap_i,
    input logic [1:0]  kind_i,
    input logic        store_i,
    input logic [63:0] vaddr_i,
    input logic        wide_i,
    input logic        exl_i,
    input logic [63:0] cur_entryhi_i,
    input logic [63:0] cur_context_i,
    input logic [63:0] cur_xcontext_i,
    input logic [63:0] badvaddr_o,
    input logic [63:0] entryhi_o,
    input logic [63:0] context_o,
    input logic [63:0] xcontext_o,
    input logic [8:0]  vec_off_o,
    input logic [4:0]  exc_code_o
);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(badvaddr_o) && $stable(entryhi_o) && $stable(context_o)
                   && $stable(xcontext_o) && $stable(vec_off_o) && $stable(exc_code_o));

    p_badv_r3: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> badvaddr_o == $past(vaddr_i));

    p_wide_ctx_kept_r5: assert property (@(posedge clk) disable iff (rst)
        cap_i && wide_i |=> context_o == $past(cur_context_i));

    p_narrow_sext_r6: assert property (@(posedge clk) disable iff (rst)
        cap_i && !wide_i |=> (entryhi_o[63:32] == {32{entryhi_o[31]}}));

    p_narrow_xctx_kept_r7: assert property (@(posedge clk) disable iff (rst)
        cap_i && !wide_i |=> xcontext_o == $past(cur_xcontext_i));

    p_refill_exl_r9: assert property (@(posedge clk) disable iff (rst)
        cap_i && kind_i == 2'd0 && exl_i |=> vec_off_o == 9'h180);

    p_general_r10: assert property (@(posedge clk) disable iff (rst)
        cap_i && kind_i != 2'd0 |=> vec_off_o == 9'h180);

    p_modify_code_r11: assert property (@(posedge clk) disable iff (rst)
        cap_i && kind_i == 2'd2 |=> exc_code_o == 5'd1);
endmodule

bind tlbf_capture tlbf_capture_chk u_chk (.*);

// File: tb/tb_tlbf_capture.sv
module tb_tlbf_capture;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cap_i;
    logic [1:0]  kind_i;
    logic        store_i;
    logic [63:0] vaddr_i;
    logic        wide_i;
    logic        exl_i;
    logic [63:0] cur_entryhi_i, cur_context_i, cur_xcontext_i;
    logic [63:0] badvaddr_o, entryhi_o, context_o, xcontext_o;
    logic [8:0]  vec_off_o;
    logic [4:0]  exc_code_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [63:0] e_badv, e_ehi, e_ctx, e_xctx;
    logic [8:0]  e_off;
    logic [4:0]  e_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbf_capture dut (.*);

    function automatic logic [63:0] f_ehi(logic [63:0] va, logic w, logic [63:0] cur);
        logic [31:0] lo;
        if (w) return {va[63:62], 22'b0, va[39:13], 5'b0, cur[7:0]};
        lo = {va[31:13], 5'b0, cur[7:0]};
        return {{32{lo[31]}}, lo};
    endfunction

    function automatic logic [63:0] f_ctx(logic [63:0] va, logic w, logic [63:0] cur);
        if (w) return cur;
        return {cur[63:23], va[31:13], cur[3:0]};
    endfunction

    function automatic logic [63:0] f_xctx(logic [63:0] va, logic w, logic [63:0] cur);
        if (!w) return cur;
        return {cur[63:33], va[63:62], va[39:13], cur[3:0]};
    endfunction

    function automatic logic [8:0] f_off(logic [1:0] k, logic w, logic x);
        if (k == 2'd0 && !x) return w ? 9'h080 : 9'h000;
        return 9'h180;
    endfunction

    function automatic logic [4:0] f_code(logic [1:0] k, logic st);
        if (k == 2'd2) return 5'd1;
        return st ? 5'd3 : 5'd2;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string tag, string r_ehi, string r_ctx, string r_off);
        chk({tag, " R3 badvaddr"}, badvaddr_o, e_badv);
        chk({tag, " ", r_ehi, " entryhi"}, entryhi_o, e_ehi);
        chk({tag, " ", r_ctx, " context"}, context_o, e_ctx);
        chk({tag, " ", r_ctx, " xcontext"}, xcontext_o, e_xctx);
        chk({tag, " ", r_off, " offset"}, {55'b0, vec_off_o}, {55'b0, e_off});
        chk({tag, " R11 code"}, {59'b0, exc_code_o}, {59'b0, e_code});
    endtask

    task automatic capture(logic [1:0] k, logic st, logic [63:0] va, logic w, logic x,
                           logic [63:0] eh, logic [63:0] cx, logic [63:0] xx);
        string r_off;
        cap_i = 1'b1; kind_i = k; store_i = st; vaddr_i = va; wide_i = w; exl_i = x;
        cur_entryhi_i = eh; cur_context_i = cx; cur_xcontext_i = xx;
        e_badv = va;
        e_ehi  = f_ehi(va, w, eh);
        e_ctx  = f_ctx(va, w, cx);
        e_xctx = f_xctx(va, w, xx);
        e_off  = f_off(k, w, x);
        e_code = f_code(k, st);
        @(posedge clk);
        @(negedge clk);
        cap_i = 1'b0;
        if (k != 2'd0) r_off = "R10";
        else if (x) r_off = "R9";
        else r_off = "R8";
        check_all("cap", w ? "R4" : "R6", w ? "R5" : "R7", r_off);
    endtask

    task automatic idle_scramble();
        cap_i = 1'b0;
        kind_i = 2'($urandom); store_i = 1'($urandom); wide_i = 1'($urandom);
        exl_i = 1'($urandom);
        vaddr_i = {$urandom, $urandom};
        cur_entryhi_i = {$urandom, $urandom};
        cur_context_i = {$urandom, $urandom};
        cur_xcontext_i = {$urandom, $urandom};
        @(posedge clk);
        @(negedge clk);
        check_all("idle R2", "R2", "R2", "R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_7a1b));
        rst = 1'b1; cap_i = 1'b1; kind_i = 2'd0; store_i = 1'b1; wide_i = 1'b1;
        exl_i = 1'b0; vaddr_i = '1; cur_entryhi_i = '1; cur_context_i = '1;
        cur_xcontext_i = '1;
        repeat (3) @(negedge clk);
        e_badv = '0; e_ehi = '0; e_ctx = '0; e_xctx = '0; e_off = '0; e_code = '0;
        check_all("reset R1", "R1", "R1", "R1");
        rst = 1'b0; cap_i = 1'b0;
        @(negedge clk);
        check_all("post-reset R1", "R1", "R1", "R1");

        // directed corners: all-ones and all-zeros surroundings, both modes
        capture(2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, '1, '1, '1);
        capture(2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, '1, '1, '1);
        capture(2'd0, 1'b0, 64'h0000_0000_8000_2000, 1'b0, 1'b0, '0, '0, '0);
        capture(2'd0, 1'b1, 64'h0000_0000_7FFF_E000, 1'b0, 1'b1, 64'hAB, '1, '0);
        capture(2'd0, 1'b0, 64'hC000_00AB_CDEF_0000, 1'b1, 1'b1, 64'h5A, '0, '1);
        capture(2'd1, 1'b1, 64'h4000_0012_3456_7000, 1'b1, 1'b0, 64'h11, '1, '0);
        capture(2'd2, 1'b1, 64'h8000_0000_0000_1FFF, 1'b0, 1'b0, 64'h22, '0, '1);
        capture(2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, 64'h33, '1, '1);
        capture(2'd2, 1'b0, 64'h0, 1'b1, 1'b1, '0, '0, '0);
        idle_scramble();

        for (int i = 0; i < 400; i++) begin
            capture(2'($urandom), 1'($urandom), {$urandom, $urandom}, 1'($urandom),
                    1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                    {$urandom, $urandom});
            if ($urandom_range(0, 2) == 0) idle_scramble();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule